// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block keeps a device in reset after power-on until its supply and its primary clock can be trusted. A power-on pulse starts several delay counters at once. A power-up timer counts a slow reference clock when its enable bit is low. For crystal oscillator modes, a start-up counter then counts oscillator cycles. In the PLL crystal mode, a further lock wait follows on the reference clock. A fixed controller-ready delay runs next to this chain, counted from the same power-on edge. Reset is released only when every delay that applies has ended.

The block runs on one always-on clock. The reference clock and the oscillator clock arrive as single-cycle tick enables on that clock. When the fast internal oscillator is the primary clock, an option bit chooses one of two behaviours: the system clock enable waits until the oscillator reports stable, or it starts together with the release. A status flag copies the stable indication in every mode. A new power-on pulse at any time restarts the whole sequence.

Top module: `pwrup_seq`

## Requirements
- R1: While `por` is high, all delay counts return to zero. On the clock edge where `por` is high, `rst_hold` is set to 1, and `sysclk_en` and `hf_ready` are set to 0. A pulse in the middle of a sequence restarts every delay from zero.
- R2: When `pwrt_off` is 0, the power-up timer must count `PWRT_TICKS` reference ticks before release. When `pwrt_off` is 1, the timer adds no delay.
- R3: In crystal modes (`osc_mode` 0 low-power, 1 standard, 2 high-speed, 3 high-speed PLL), the start-up counter counts `OST_CYCLES` oscillator ticks. It begins only after the power-up timer has finished or is disabled.
- R4: In mode 3, release is held for a further `PLL_TICKS` reference ticks. This wait starts after the start-up count completes.
- R5: The controller-ready delay counts `RDY_TICKS` reference ticks from the power-on edge. It runs at the same time as the other delays, not after them.
- R6: In modes 4 (external clock), 5 (RC), 6 (fast internal) and 7 (slow internal), only the power-up timer and the controller-ready delay apply. Oscillator ticks have no effect in these modes.
- R7: `rst_hold` falls on the clock edge after the last applicable delay finishes. It then stays low until the next `por`. `sysclk_en` is never high while `rst_hold` is high.
- R8: In mode 6 with `hf_wait_skip` = 0, `sysclk_en` goes high only on an edge where `hf_stable` is 1. With `hf_wait_skip` = 1, or in any other mode, `sysclk_en` rises on the same edge as the release.
- R9: Outside `por`, `hf_ready` equals the `hf_stable` value from the previous edge, in every mode and option setting.
- R10: A counter advances only on a cycle where its tick is high and its stage is active. It stops at its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| por | input | 1 | Power-on reset pulse, synchronous, active high |
| osc_mode | input | 3 | Primary oscillator mode code (0..7) |
| pwrt_off | input | 1 | Power-up timer disable; timer active when 0 |
| hf_wait_skip | input | 1 | 1: system clock starts without waiting for the fast internal oscillator |
| hf_stable | input | 1 | Fast internal oscillator running and stable |
| ref_tick | input | 1 | One-cycle pulse per slow reference clock period |
| osc_tick | input | 1 | One-cycle pulse per primary oscillator cycle |
| rst_hold | output | 1 | Device held in reset |
| sysclk_en | output | 1 | System clock enable |
| hf_ready | output | 1 | Status: fast internal oscillator stable |

## Verification
Directed runs hold every tick high and compare the cycle in which the release comes against delay sums worked out by hand. Crystal versus non-crystal, PLL versus plain high-speed, and timer on versus off each give a different sum, so any mis-chained or missing stage shows up as a wrong release cycle. Further runs hold the ticks low to show that the counters only advance on ticks. They also pulse `por` part way through, and step the fast internal oscillator's stable flag with the wait option set and clear. Random runs draw the mode, options, sparse tick patterns, a toggling stable flag and occasional power-on pulses. A cycle-level bench model checks every output on every cycle of these runs.

// File: rtl/pwrup_pkg.sv
`timescale 1ns/1ps
package pwrup_pkg;

    typedef enum logic [2:0] {
        OSC_LP        = 3'd0,
        OSC_XT        = 3'd1,
        OSC_HS        = 3'd2,
        OSC_HSPLL     = 3'd3,
        OSC_EXT       = 3'd4,
        OSC_RC        = 3'd5,
        OSC_INT_FAST  = 3'd6,
        OSC_INT_SLOW  = 3'd7
    } osc_mode_e;

    // stage finished (or not applicable) flags
    typedef struct packed {
        logic pwrt;
        logic ost;
        logic pll;
        logic rdy;
    } stage_done_t;

    localparam int unsigned NUM_STAGES = 4;
    localparam int unsigned STG_PWRT   = 0;
    localparam int unsigned STG_OST    = 1;
    localparam int unsigned STG_PLL    = 2;
    localparam int unsigned STG_RDY    = 3;

    function automatic logic mode_is_crystal(osc_mode_e m);
        return (m == OSC_LP) || (m == OSC_XT) || (m == OSC_HS) || (m == OSC_HSPLL);
    endfunction

    function automatic logic mode_uses_pll(osc_mode_e m);
        return m == OSC_HSPLL;
    endfunction

endpackage

// File: rtl/pwrup_tick_ctr.sv
`timescale 1ns/1ps
module pwrup_tick_ctr #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TERM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    assign done = (cnt == TERM);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else if (run && tick && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (clr)
        cnt <= TERM);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (clr)
        !(run && tick) |=> $stable(cnt));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (clr)
        done |=> done);

endmodule

// File: rtl/pwrup_release.sv
`timescale 1ns/1ps
module pwrup_release
    import pwrup_pkg::*;
(
    input  logic        clk,
    input  logic        por,
    input  stage_done_t stg,
    input  logic        gate_ok,
    input  logic        hf_stable,
    output logic        rst_hold,
    output logic        sysclk_en,
    output logic        hf_ready
);
    logic all_done;
    assign all_done = &stg;

    always_ff @(posedge clk) begin
        if (por) begin
            rst_hold  <= 1'b1;
            sysclk_en <= 1'b0;
            hf_ready  <= 1'b0;
        end else begin
            rst_hold  <= !all_done;
            sysclk_en <= all_done && gate_ok;
            hf_ready  <= hf_stable;
        end
    end

    // R1
    por_hold_chk: assert property (@(posedge clk)
        por |=> (rst_hold && !sysclk_en && !hf_ready));

    // R7
    en_needs_release_chk: assert property (@(posedge clk) disable iff (por)
        sysclk_en |-> !rst_hold);

    // R7
    release_sticky_chk: assert property (@(posedge clk) disable iff (por)
        !rst_hold |=> !rst_hold);

    // R8
    fast_gate_chk: assert property (@(posedge clk) disable iff (por)
        $rose(sysclk_en) |-> $past(gate_ok));

    // R9
    status_follow_chk: assert property (@(posedge clk) disable iff (por)
        !por |=> (hf_ready == $past(hf_stable)));

endmodule

// File: rtl/pwrup_seq.sv
`timescale 1ns/1ps
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int unsigned PWRT_TICKS = 64,
    parameter int unsigned OST_CYCLES = 1024,
    parameter int unsigned PLL_TICKS  = 64,
    parameter int unsigned RDY_TICKS  = 8
) (
    input  logic       clk,
    input  logic       por,
    input  logic [2:0] osc_mode,
    input  logic       pwrt_off,
    input  logic       hf_wait_skip,
    input  logic       hf_stable,
    input  logic       ref_tick,
    input  logic       osc_tick,
    output logic       rst_hold,
    output logic       sysclk_en,
    output logic       hf_ready
);
    localparam int unsigned STG_LIMIT [NUM_STAGES] = '{PWRT_TICKS, OST_CYCLES, PLL_TICKS, RDY_TICKS};

    osc_mode_e   mode;
    logic        is_xtal;
    logic        is_pll;
    logic        gate_ok;
    stage_done_t stg;

    logic [NUM_STAGES-1:0] stg_run;
    logic [NUM_STAGES-1:0] stg_tick;
    logic [NUM_STAGES-1:0] stg_cnt_done;

    assign mode    = osc_mode_e'(osc_mode);
    assign is_xtal = mode_is_crystal(mode);
    assign is_pll  = mode_uses_pll(mode);

    // stage completion, with stages that do not apply counted as done
    assign stg.pwrt = pwrt_off || stg_cnt_done[STG_PWRT];
    assign stg.ost  = !is_xtal || stg_cnt_done[STG_OST];
    assign stg.pll  = !is_pll  || stg_cnt_done[STG_PLL];
    assign stg.rdy  = stg_cnt_done[STG_RDY];

    // chained stages start after their predecessors; ready delay is parallel
    always_comb begin
        stg_run[STG_PWRT] = !pwrt_off;
        stg_run[STG_OST]  = is_xtal && stg.pwrt;
        stg_run[STG_PLL]  = is_pll && stg.pwrt && stg.ost;
        stg_run[STG_RDY]  = 1'b1;

        stg_tick[STG_PWRT] = ref_tick;
        stg_tick[STG_OST]  = osc_tick;
        stg_tick[STG_PLL]  = ref_tick;
        stg_tick[STG_RDY]  = ref_tick;
    end

    assign gate_ok = (mode != OSC_INT_FAST) || hf_wait_skip || hf_stable;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        pwrup_tick_ctr #(
            .LIMIT (STG_LIMIT[g])
        ) u_ctr (
            .clk  (clk),
            .clr  (por),
            .run  (stg_run[g]),
            .tick (stg_tick[g]),
            .done (stg_cnt_done[g])
        );
    end

    pwrup_release u_rel (
        .clk       (clk),
        .por       (por),
        .stg       (stg),
        .gate_ok   (gate_ok),
        .hf_stable (hf_stable),
        .rst_hold  (rst_hold),
        .sysclk_en (sysclk_en),
        .hf_ready  (hf_ready)
    );

    // R3: oscillator start-up stage never finishes before the timer stage
    ost_after_pwrt_chk: assert property (@(posedge clk) disable iff (por)
        (is_xtal && !stg.pwrt) |-> !stg_cnt_done[STG_OST] || (OST_CYCLES == 0));

endmodule

// File: tb/tb_pwrup_seq.sv
`timescale 1ns/1ps
module tb_pwrup_seq;

    localparam int PW  = 50;
    localparam int OST = 64;
    localparam int PLL = 25;
    localparam int RDY = 30;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic [2:0] osc_mode = 3'd4;
    logic       pwrt_off = 1'b0;
    logic       hf_wait_skip = 1'b0;
    logic       hf_stable = 1'b0;
    logic       ref_tick = 1'b0;
    logic       osc_tick = 1'b0;
    logic       rst_hold, sysclk_en, hf_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit rnd_mode = 1'b0;
    bit rnd_stable = 1'b0;
    bit ticks_off = 1'b0;
    bit started = 1'b0;

    always #5 clk = ~clk;

    pwrup_seq #(
        .PWRT_TICKS (PW),
        .OST_CYCLES (OST),
        .PLL_TICKS  (PLL),
        .RDY_TICKS  (RDY)
    ) dut (
        .clk          (clk),
        .por          (por),
        .osc_mode     (osc_mode),
        .pwrt_off     (pwrt_off),
        .hf_wait_skip (hf_wait_skip),
        .hf_stable    (hf_stable),
        .ref_tick     (ref_tick),
        .osc_tick     (osc_tick),
        .rst_hold     (rst_hold),
        .sysclk_en    (sysclk_en),
        .hf_ready     (hf_ready)
    );

    function automatic bit f_xtal(logic [2:0] m);
        return m <= 3'd3;
    endfunction

    function automatic bit f_pll(logic [2:0] m);
        return m == 3'd3;
    endfunction

    function automatic string f_hold_tag(logic [2:0] m);
        if (f_pll(m))  return "R4";
        if (f_xtal(m)) return "R3";
        return "R6";
    endfunction

    task automatic check_eq(string req, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // cycle-level expectation model built from the requirements
    int m_pw, m_ost, m_pll, m_rdy;
    bit e_hold = 1'b1, e_en = 1'b0, e_rdy = 1'b0, e_por_prev = 1'b1;
    always @(posedge clk) begin
        bit d_pw, d_ost, d_pll, d_rdy, all;
        e_por_prev = por;
        if (por) begin
            m_pw = 0; m_ost = 0; m_pll = 0; m_rdy = 0;
            e_hold = 1'b1; e_en = 1'b0; e_rdy = 1'b0;
        end else begin
            d_pw  = pwrt_off || (m_pw >= PW);
            d_ost = !f_xtal(osc_mode) || (m_ost >= OST);
            d_pll = !f_pll(osc_mode) || (m_pll >= PLL);
            d_rdy = m_rdy >= RDY;
            all   = d_pw && d_ost && d_pll && d_rdy;
            e_hold = !all;
            e_en   = all && ((osc_mode != 3'd6) || hf_wait_skip || hf_stable);
            e_rdy  = hf_stable;
            if (!pwrt_off && ref_tick && m_pw < PW) m_pw++;
            if (f_xtal(osc_mode) && d_pw && osc_tick && m_ost < OST) m_ost++;
            if (f_pll(osc_mode) && d_pw && d_ost && ref_tick && m_pll < PLL) m_pll++;
            if (ref_tick && m_rdy < RDY) m_rdy++;
        end
    end

    // per-cycle comparison, then drive tick inputs for the next edge
    always @(negedge clk) begin
        if (started) begin
            string tg;
            tg = e_por_prev ? "R1" : f_hold_tag(osc_mode);
            check_eq(tg, "rst_hold", rst_hold, e_hold);
            tg = e_por_prev ? "R1" : "R8";
            check_eq(tg, "sysclk_en", sysclk_en, e_en);
            tg = e_por_prev ? "R1" : "R9";
            check_eq(tg, "hf_ready", hf_ready, e_rdy);
        end
        if (ticks_off) begin
            ref_tick = 1'b0;
            osc_tick = 1'b0;
        end else if (rnd_mode) begin
            ref_tick = ($urandom % 3) == 0;
            osc_tick = ($urandom % 2) == 0;
        end else begin
            ref_tick = 1'b1;
            osc_tick = 1'b1;
        end
        if (rnd_stable && ($urandom % 16) == 0) hf_stable = ~hf_stable;
    end

    // pulse por, then count edges until rst_hold is first seen low
    task automatic measure(logic [2:0] m, bit poff, int exp_n, string req);
        int k;
        @(negedge clk);
        por = 1'b1; osc_mode = m; pwrt_off = poff;
        @(negedge clk);
        por = 1'b0;
        k = 0;
        for (int i = 1; i <= exp_n + 10; i++) begin
            @(negedge clk);
            if (!rst_hold) begin k = i; break; end
        end
        check_eq(req, "release cycle", k, exp_n);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        started = 1'b1;

        // R1: reset state after por
        check_eq("R1", "rst_hold in por", rst_hold, 1);
        check_eq("R1", "sysclk_en in por", sysclk_en, 0);
        check_eq("R1", "hf_ready in por", hf_ready, 0);

        // R2 / R5 / R6: non-crystal release sums
        measure(3'd4, 1'b0, PW + 1, "R2");
        measure(3'd4, 1'b1, RDY + 1, "R5");
        measure(3'd5, 1'b1, RDY + 1, "R6");
        // R3: start-up count chained after the timer
        measure(3'd2, 1'b0, PW + OST + 1, "R3");
        measure(3'd0, 1'b1, OST + 1, "R3");
        // R4: extra PLL lock wait
        measure(3'd3, 1'b0, PW + OST + PLL + 1, "R4");

        // R7: stays released with no further events
        repeat (20) @(negedge clk);
        check_eq("R7", "rst_hold stays low", rst_hold, 0);

        // R1: por in mid-sequence restarts all counts
        @(negedge clk); por = 1'b1; osc_mode = 3'd3; pwrt_off = 1'b0;
        @(negedge clk); por = 1'b0;
        repeat (80) @(negedge clk);
        measure(3'd3, 1'b0, PW + OST + PLL + 1, "R1");

        // R10: no ticks, no progress
        ticks_off = 1'b1;
        @(negedge clk); por = 1'b1; osc_mode = 3'd2; pwrt_off = 1'b1;
        @(negedge clk); por = 1'b0;
        repeat (200) @(negedge clk);
        check_eq("R10", "held without ticks", rst_hold, 1);
        ticks_off = 1'b0;
        measure(3'd2, 1'b1, OST + 1, "R10");

        // R8: fast internal oscillator, wait option clear
        hf_wait_skip = 1'b0; hf_stable = 1'b0;
        measure(3'd6, 1'b1, RDY + 1, "R8");
        repeat (5) @(negedge clk);
        check_eq("R8", "clock gated until stable", sysclk_en, 0);
        hf_stable = 1'b1;
        @(negedge clk);
        check_eq("R8", "clock on after stable", sysclk_en, 1);
        check_eq("R9", "status follows stable", hf_ready, 1);
        // R8: wait option set starts clock with release
        hf_wait_skip = 1'b1; hf_stable = 1'b0;
        measure(3'd6, 1'b1, RDY + 1, "R8");
        check_eq("R8", "clock with release when skipping", sysclk_en, 1);
        check_eq("R9", "status low while unstable", hf_ready, 0);

        // random runs
        rnd_mode = 1'b1; rnd_stable = 1'b1;
        for (int r = 0; r < 40; r++) begin
            @(negedge clk);
            por = 1'b1;
            osc_mode = 3'($urandom % 8);
            pwrt_off = $urandom % 2;
            hf_wait_skip = $urandom % 2;
            @(negedge clk);
            por = 1'b0;
            for (int c = 0; c < 350 + int'($urandom % 300); c++) begin
                @(negedge clk);
                por = (($urandom % 300) == 0);
            end
        end

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule